// File: doc/BRIEF.md
# Monostable/Astable Pulse Channel

This block is a single pulse-generation channel driven by a 48 MHz clock, so one count is about 20.83 ns. It drives one output line and runs in one of two modes. In monostable mode, each trigger produces one timed pulse, or a burst of pulses. A trigger is either an edge on the external input or a one-cycle software strobe. In astable mode, the same external input acts as a gate, and the channel oscillates while the gate is active.

Timing comes from quasi-static configuration inputs:
- the active (high) time and inactive (low) time, each a 32-bit cycle count;
- an 8-bit burst count;
- a retrigger enable;
- separate polarity selects for the gate, the trigger and the output.

A burst runs at a 1:1 mark-space ratio, using the high time for both phases. Configuration is sampled only when a period starts. Any change therefore appears from the next period onward.

Top module: `pulse_channel`

## Requirements
- R1: While reset is asserted, and in idle after it, the output sits at its inactive level, which equals `cfg_out_inv`.
- R2: In monostable mode (`cfg_astable`=0), a `sw_trig` strobe seen in idle at a clock edge makes the output active after that edge, for exactly `cfg_high` cycles. The channel then returns to idle.
- R3: `ext_in` passes through a two-flop synchronizer. In monostable mode, a trigger is the rising edge of the synchronized input when `cfg_trig_inv`=0, and its falling edge when `cfg_trig_inv`=1. The opposite edge, and a change of `cfg_trig_inv` alone, start nothing. The output goes active after the third clock edge following the input change.
- R4: With `cfg_retrig`=0, triggers that arrive during an active pulse are ignored, and the pulse keeps its programmed width.
- R5: With `cfg_retrig`=1, a monostable trigger during the active phase restarts the high count. A strobe k cycles after the pulse started gives a width of k+`cfg_high`.
- R6: In astable mode, the gate is active when the synchronized `ext_in` differs from `cfg_gate_inv`. The channel starts oscillating three edges after the gate becomes active. It repeats `cfg_high` active cycles followed by `cfg_low` inactive cycles. A new period starts only if the gate is still active when the previous period ends, so a period in progress always completes. `sw_trig` has no effect in astable mode.
- R7: A nonzero `cfg_burst` value N gives N pulses. Each pulse is `cfg_high` cycles active with `cfg_high` cycles inactive between pulses; `cfg_low` is ignored. In monostable mode the channel then returns to idle. In astable mode it holds inactive until the gate goes inactive, and the next gate activation starts a new burst.
- R8: `cfg_burst`=0 means a single pulse per trigger in monostable mode, and continuous oscillation in astable mode.
- R9: High and low counts below 5 are treated as 5, which sets the narrowest phase to 5 cycles.
- R10: `cfg_out_inv`=1 inverts the output line: active is low and inactive is high.
- R11: Changes to `cfg_high` or `cfg_low` during a period do not alter that period. They apply from the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz channel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_astable | input | 1 | 1 = gated oscillator, 0 = triggered single shot |
| cfg_high | input | CNT_W | Active-phase length in cycles |
| cfg_low | input | CNT_W | Inactive-phase length in cycles (non-burst) |
| cfg_burst | input | BURST_W | Pulses per burst; 0 = no burst |
| cfg_retrig | input | 1 | Allow a trigger to restart an active pulse |
| cfg_gate_inv | input | 1 | Gate is active-low when set |
| cfg_trig_inv | input | 1 | Trigger on falling input edge when set |
| cfg_out_inv | input | 1 | Output active-low when set |
| ext_in | input | 1 | Asynchronous gate/trigger input |
| sw_trig | input | 1 | Synchronous one-cycle software trigger |
| pulse_out | output | 1 | Pulse output |

## Verification
Several input patterns are tried, and each is meant to tell two behaviours apart:
- **Software strobes against edges on the external input.** This separates the direct trigger path from the synchronized path, which has a two-cycle offset.
- **Rising and falling input edges under both trigger polarities.** This shows whether the edge selection is correct or reversed.
- **Paired strobes with and without retrigger.** The first case gives a nominal width and the second an extended one.
- **A gate held open, a gate dropped mid-period, and inverted gate polarity.** Together these expose early truncation and wrong counts of periods.
- **Bursts in both modes.** Pulse spacing shows whether the low count is wrongly used in bursts, and a held gate shows whether an astable burst re-arms on its own.
- **A mid-period change of the high count.** This shows whether the configuration is sampled at the period start or read live.

// File: rtl/pulse_channel.sv
module pulse_channel #(
  parameter int CNT_W   = 32,
  parameter int BURST_W = 8,
  parameter int MIN_LEN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_astable,
  input  logic [CNT_W-1:0]   cfg_high,
  input  logic [CNT_W-1:0]   cfg_low,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic               cfg_retrig,
  input  logic               cfg_gate_inv,
  input  logic               cfg_trig_inv,
  input  logic               cfg_out_inv,
  input  logic               ext_in,
  input  logic               sw_trig,
  output logic               pulse_out
);

  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_LOW, S_HOLD} st_t;

  st_t                st;
  logic [2:0]         sync_q;
  logic [CNT_W-1:0]   cnt, hi_q, lo_q;
  logic [BURST_W-1:0] rem;
  logic               ast_q, bm_q;

  wire gate_on  = sync_q[1] ^ cfg_gate_inv;
  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire ext_trig = cfg_trig_inv ? fall : rise;
  wire trig     = ext_trig | sw_trig;

  wire [CNT_W-1:0] hi_eff = (cfg_high < MIN_C) ? MIN_C : cfg_high;
  wire [CNT_W-1:0] lo_eff = (cfg_low  < MIN_C) ? MIN_C : cfg_low;
  wire             bm_new = (cfg_burst != '0);

  wire start_idle = cfg_astable ? gate_on : trig;
  wire last_pulse = bm_q ? (rem == BURST_W'(1)) : !ast_q;

  assign pulse_out = (st == S_HIGH) ^ cfg_out_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      hi_q  <= MIN_C;
      lo_q  <= MIN_C;
      rem   <= '0;
      ast_q <= 1'b0;
      bm_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start_idle) begin
          st    <= S_HIGH;
          cnt   <= hi_eff - ONE_C;
          hi_q  <= hi_eff;
          lo_q  <= bm_new ? hi_eff : lo_eff;
          rem   <= cfg_burst;
          bm_q  <= bm_new;
          ast_q <= cfg_astable;
        end
        S_HIGH: begin
          if (!ast_q && cfg_retrig && trig) begin
            cnt <= hi_q - ONE_C;
          end else if (cnt != '0) begin
            cnt <= cnt - ONE_C;
          end else if (last_pulse) begin
            st <= ast_q ? S_HOLD : S_IDLE;
          end else begin
            st  <= S_LOW;
            cnt <= lo_q - ONE_C;
            if (bm_q) rem <= rem - BURST_W'(1);
          end
        end
        S_LOW: begin
          if (cnt != '0) begin
            cnt <= cnt - ONE_C;
          end else if (ast_q && !gate_on) begin
            st <= S_IDLE;
          end else begin
            st   <= S_HIGH;
            cnt  <= hi_eff - ONE_C;
            hi_q <= hi_eff;
            lo_q <= bm_q ? hi_eff : lo_eff;
          end
        end
        S_HOLD: if (!gate_on) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module pulse_channel_chk #(
  parameter int CNT_W   = 32,
  parameter int BURST_W = 8,
  parameter int MIN_LEN = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         st,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   hi_q,
  input logic [BURST_W-1:0] rem,
  input logic               ast_q,
  input logic               bm_q,
  input logic               cfg_astable,
  input logic               cfg_retrig,
  input logic               sw_trig
);
  localparam logic [1:0] IDLE = 2'd0, HIGH = 2'd1, LOW = 2'd2, HOLD = 2'd3;

  a_r2_strobe_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && !cfg_astable && sw_trig) |=> (st == HIGH));

  a_r4_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HIGH && cnt != '0 && !cfg_retrig) |=> (st == HIGH && cnt == $past(cnt) - 1'b1));

  a_r5_retrig_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HIGH && !ast_q && cfg_retrig && sw_trig) |=> (st == HIGH && cnt == hi_q - 1'b1));

  a_r9_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == HIGH) |-> (cnt >= CNT_W'(MIN_LEN - 1)));

  a_r7_burst_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_q && (st == HIGH || st == LOW)) |-> (rem != '0));

  a_r7_hold_only_astable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> ast_q);
endmodule

bind pulse_channel pulse_channel_chk #(.CNT_W(CNT_W), .BURST_W(BURST_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .hi_q(hi_q), .rem(rem),
  .ast_q(ast_q), .bm_q(bm_q), .cfg_astable(cfg_astable),
  .cfg_retrig(cfg_retrig), .sw_trig(sw_trig)
);

// File: tb/test_pulse_channel.sv
`timescale 1ns/1ps
module test_pulse_channel;
  logic        clk = 0, rst_n = 0;
  logic        cfg_astable = 0, cfg_retrig = 0;
  logic [31:0] cfg_high = 10, cfg_low = 10;
  logic [7:0]  cfg_burst = 0;
  logic        cfg_gate_inv = 0, cfg_trig_inv = 0, cfg_out_inv = 0;
  logic        ext_in = 0, sw_trig = 0;
  logic        pulse_out;

  pulse_channel i_pulse_channel (
    .clk(clk), .rst_n(rst_n), .cfg_astable(cfg_astable), .cfg_high(cfg_high),
    .cfg_low(cfg_low), .cfg_burst(cfg_burst), .cfg_retrig(cfg_retrig),
    .cfg_gate_inv(cfg_gate_inv), .cfg_trig_inv(cfg_trig_inv),
    .cfg_out_inv(cfg_out_inv), .ext_in(ext_in), .sw_trig(sw_trig),
    .pulse_out(pulse_out)
  );

  always #2.5 clk = ~clk;

  int    cyc = 0, vecs = 0, errs = 0;
  int    q_start[$], q_width[$];
  string q_req[$];
  bit    oinv = 0, prev = 0;
  int    rs = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_pulse(int s, int w, string r);
    q_start.push_back(s); q_width.push_back(w); q_req.push_back(r);
  endtask

  always @(negedge clk) begin
    bit act;
    act = pulse_out ^ oinv;
    if (rst_n) begin
      if (act && !prev) rs = cyc;
      if (!act && prev) begin
        vecs++;
        if (q_start.size() == 0) begin
          errs++;
          $display("FAIL unexpected pulse: actual start %0d width %0d, expected none", rs, cyc - rs);
        end else begin
          int s, w; string r;
          s = q_start.pop_front(); w = q_width.pop_front(); r = q_req.pop_front();
          if (s != rs || w != cyc - rs) begin
            errs++;
            $display("FAIL %s pulse: actual start %0d width %0d, expected start %0d width %0d",
                     r, rs, cyc - rs, s, w);
          end
        end
      end
    end
    prev = act;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) step();
  endtask

  task automatic until_cyc(int t);
    while (cyc < t) step();
  endtask

  task automatic drained(string r);
    vecs++;
    if (q_start.size() != 0) begin
      errs++;
      $display("FAIL %s missing pulses: actual %0d outstanding, expected 0", r, q_start.size());
      q_start.delete(); q_width.delete(); q_req.delete();
    end
  endtask

  task automatic check_level(logic e, string r);
    vecs++;
    if (pulse_out !== e) begin
      errs++;
      $display("FAIL %s level: actual %b expected %b", r, pulse_out, e);
    end
  endtask

  task automatic strobe();
    sw_trig = 1; step(); sw_trig = 0;
  endtask

  initial begin
    int c, d, t0;
    wait_cyc(4);
    check_level(1'b0, "R1");
    rst_n = 1;
    wait_cyc(3);
    check_level(1'b0, "R1");

    // R2 R8: single software-triggered pulse
    c = cyc; expect_pulse(c + 1, 10, "R2"); strobe();
    wait_cyc(30); drained("R2");

    // R3: synchronized edges with both trigger polarities
    cfg_high = 12; step();
    c = cyc; expect_pulse(c + 3, 12, "R3"); ext_in = 1;
    wait_cyc(40); ext_in = 0; wait_cyc(30); drained("R3");
    cfg_trig_inv = 1; ext_in = 1; wait_cyc(30); drained("R3");
    c = cyc; expect_pulse(c + 3, 12, "R3"); ext_in = 0;
    wait_cyc(40); drained("R3");
    cfg_trig_inv = 0; wait_cyc(10); drained("R3");

    // R4: second trigger ignored
    cfg_high = 20; step();
    c = cyc; expect_pulse(c + 1, 20, "R4"); strobe();
    until_cyc(c + 5); strobe();
    wait_cyc(40); drained("R4");

    // R5: retrigger extends
    cfg_retrig = 1; step();
    c = cyc; expect_pulse(c + 1, 25, "R5"); strobe();
    until_cyc(c + 5); strobe();
    wait_cyc(50); drained("R5");
    cfg_retrig = 0;

    // R9: clamp to 5
    cfg_high = 2; step();
    c = cyc; expect_pulse(c + 1, 5, "R9"); strobe();
    wait_cyc(20); drained("R9");
    cfg_high = 0; step();
    c = cyc; expect_pulse(c + 1, 5, "R9"); strobe();
    wait_cyc(20); drained("R9");

    // R7: monostable burst, low ignored
    cfg_high = 6; cfg_low = 50; cfg_burst = 3; step();
    c = cyc;
    expect_pulse(c + 1, 6, "R7"); expect_pulse(c + 13, 6, "R7"); expect_pulse(c + 25, 6, "R7");
    strobe(); wait_cyc(80); drained("R7");
    cfg_burst = 0;

    // R6 R8: continuous astable, gate drop mid period
    cfg_astable = 1; cfg_high = 7; cfg_low = 9; step();
    c = cyc;
    for (int k = 0; k < 4; k++) expect_pulse(c + 3 + 16 * k, 7, "R8");
    ext_in = 1;
    d = c + 3 + 48 + 4;
    until_cyc(d); ext_in = 0;
    wait_cyc(40); drained("R6");
    c = cyc; expect_pulse(-1, 0, "R6"); strobe(); wait_cyc(20);
    vecs++;
    if (q_start.size() != 1) begin
      errs++; $display("FAIL R6 strobe in astable: actual pulse, expected none");
    end
    q_start.delete(); q_width.delete(); q_req.delete();

    // R6: inverted gate polarity
    cfg_astable = 0; cfg_trig_inv = 1; step(); ext_in = 1; wait_cyc(10);
    cfg_astable = 1; cfg_gate_inv = 1; wait_cyc(30); drained("R6");
    c = cyc;
    expect_pulse(c + 3, 7, "R6"); expect_pulse(c + 19, 7, "R6");
    ext_in = 0;
    d = c + 3 + 16 + 2;
    until_cyc(d); ext_in = 1;
    wait_cyc(40); drained("R6");
    cfg_astable = 0; step(); cfg_gate_inv = 0; cfg_trig_inv = 0; step();
    ext_in = 0; wait_cyc(20); drained("R6");

    // R7: astable burst holds, re-arms on new gate
    cfg_astable = 1; cfg_burst = 2; cfg_high = 8; cfg_low = 3; step();
    c = cyc; expect_pulse(c + 3, 8, "R7"); expect_pulse(c + 19, 8, "R7");
    ext_in = 1; wait_cyc(100); drained("R7");
    ext_in = 0; wait_cyc(10);
    c = cyc; expect_pulse(c + 3, 8, "R7"); expect_pulse(c + 19, 8, "R7");
    ext_in = 1; wait_cyc(60); drained("R7");
    ext_in = 0; cfg_burst = 0; wait_cyc(10);

    // R11: config applies from next period
    cfg_high = 7; cfg_low = 9; step();
    c = cyc; t0 = c + 3;
    expect_pulse(t0, 7, "R11"); expect_pulse(t0 + 16, 20, "R11"); expect_pulse(t0 + 45, 20, "R11");
    ext_in = 1;
    until_cyc(t0 + 2); cfg_high = 20;
    until_cyc(t0 + 48); ext_in = 0;
    wait_cyc(60); drained("R11");

    // R10: inverted output
    cfg_astable = 0; cfg_high = 10; cfg_out_inv = 1; oinv = 1; step();
    check_level(1'b1, "R10");
    c = cyc; expect_pulse(c + 1, 10, "R10"); strobe();
    step(); check_level(1'b0, "R10");
    wait_cyc(30); drained("R10");
    check_level(1'b1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errs++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule